// File: doc/BRIEF.md
# Prioritized Interrupt Level Resolver

This block decides whether a pending interrupt should interrupt the core. It has two request sources. The first is a software request register, written through a masked write port. The second is a vector of external request lines. Each source is scanned for its highest active bit, and that bit is turned into a priority level. An active external level takes precedence over any software level.

The resolved level is compared against a programmable 5-bit current priority level. A trap is requested only when the resolved level is strictly higher. At the same moment, the one-hot summary of every active request and the winning level are captured into two status registers, which stay readable at the outputs.

Evaluation is governed by a small arm/disarm state machine:

- `ST_ARMED`: a check pulse performs one evaluation.
  - Transition `evaluate_take` goes to `ST_FIRE` when the trap condition holds.
  - Transition `evaluate_drop` goes to `ST_DISARMED` otherwise.
- `ST_FIRE`: drives the trap request for one cycle.
  - Transition `fire_done` goes to `ST_DISARMED`.
  - Transition `fire_rearm` goes back to `ST_ARMED` if a return-from-exception arrives in that cycle.
- `ST_DISARMED`: waits.
  - Transition `rearm` goes to `ST_ARMED` on a return-from-exception pulse.

Top module: `irq_level_resolver`

## Requirements
- R1: Writes to the software request register keep only bits 4 through 18 (mask 0x0007_fff0). An active software bit i maps to level i − 3, so bit 4 gives level 1 and bit 18 gives level 15.
- R2: An active external line at bit i, for i from 20 to 29, maps to level i. External bits outside 20..29 have no effect on level or summary.
- R3: Within each source the highest active bit sets that source's level. Any active external request overrides the software level.
- R4: The summary is the bitwise OR of the surviving software bits and the in-range external bits, each at its own bit position.
- R5: A trap is requested only when the resolved level is nonzero and strictly greater than the current priority level. Equal or lower levels give no trap.
- R6: Writes to the current priority level keep only the low 5 bits of the written data.
- R7: When a trap is taken, the summary and the level are captured into `isr_o` and `intid_o`. Otherwise both outputs hold their values.
- R8: `trap_o` is high for exactly one cycle. It appears in the cycle after the clock edge at which an armed check pulse is sampled.
- R9: The block leaves reset armed. Every armed check disarms it, whether or not a trap results. A check while disarmed or during the trap cycle is ignored. Only a return-from-exception pulse re-arms it; a return-from-exception arriving together with a check while disarmed arms without evaluating.
- R10: After reset `trap_o`, `isr_o` and `intid_o` are zero, and the software request register and the current priority level are cleared.
- R11: An evaluation uses the register contents from before the edge. A software request write in the same cycle as the check affects only later checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_i | input | 1 | Write strobe for the software request register |
| sw_wdata_i | input | 32 | Software request write data (masked) |
| lvl_wr_i | input | 1 | Write strobe for the current priority level |
| lvl_wdata_i | input | 32 | Priority level write data (low 5 bits kept) |
| ext_req_i | input | 32 | External interrupt request lines |
| chk_i | input | 1 | Check pulse: evaluate when armed |
| rfe_i | input | 1 | Return-from-exception pulse: re-arm |
| trap_o | output | 1 | One-cycle interrupt trap request |
| isr_o | output | 32 | Captured summary of active requests |
| intid_o | output | 5 | Captured winning level |

## Verification
The bench pushes on the edges of the priority compare:

- A level equal to the threshold must not trap. A design using greater-or-equal would fire there.
- A level just above the threshold must trap.
- A level of zero with a threshold of zero must not trap.

Write data with every bit set exposes a wrong software mask or a wrong level offset. Either shows up as an extra summary bit or an off-by-one `intid_o`.

External lines below and above the valid window are driven to catch a scanner that ignores its range. A second check without a return-from-exception, and a re-arm coinciding with a check, catch a state machine that fails to disarm or evaluates while re-arming. A software write coinciding with a check catches evaluation on post-write data.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int SUM_W  = 32;
    localparam int DATA_W = 32;
    localparam int LVL_W  = 5;
    localparam int SW_LO  = 4;
    localparam int SW_HI  = 19;
    localparam int EXT_LO = 20;
    localparam int EXT_HI = 30;

    typedef enum logic [1:0] {
        ST_ARMED    = 2'd0,
        ST_FIRE     = 2'd1,
        ST_DISARMED = 2'd2
    } arm_state_e;
endpackage

// File: rtl/irq_prio_scan.sv
module irq_prio_scan #(
    parameter int W     = 32,
    parameter int LO    = 4,
    parameter int HI    = 19,
    parameter int OFS   = 3,
    parameter int LVL_W = 5
) (
    input  logic [W-1:0]     req_i,
    output logic [LVL_W-1:0] lvl_o,
    output logic [W-1:0]     hit_o
);
    function automatic logic [W-1:0] window_mask();
        logic [W-1:0] m;
        for (int i = 0; i < W; i++) begin
            m[i] = (i >= LO) && (i < HI);
        end
        return m;
    endfunction

    localparam logic [W-1:0] WIN = window_mask();

    // ascending scan: the last (highest) active bit wins
    always_comb begin
        lvl_o = '0;
        for (int i = LO; i < HI; i++) begin
            if (req_i[i]) begin
                lvl_o = LVL_W'(i - OFS);
            end
        end
    end

    assign hit_o = req_i & WIN;
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick #(
    parameter int SUM_W    = 32,
    parameter int LVL_W    = 5,
    parameter bit EXT_WINS = 1'b1
) (
    input  logic [LVL_W-1:0] sw_lvl_i,
    input  logic [LVL_W-1:0] ext_lvl_i,
    input  logic [SUM_W-1:0] sw_hit_i,
    input  logic [SUM_W-1:0] ext_hit_i,
    input  logic [LVL_W-1:0] ipl_i,
    output logic [LVL_W-1:0] lvl_o,
    output logic [SUM_W-1:0] sum_o,
    output logic             above_o
);
    generate
        if (EXT_WINS) begin : g_ext_first
            assign lvl_o = (ext_lvl_i != '0) ? ext_lvl_i : sw_lvl_i;
        end else begin : g_sw_first
            assign lvl_o = (sw_lvl_i != '0) ? sw_lvl_i : ext_lvl_i;
        end
    endgenerate

    assign sum_o   = sw_hit_i | ext_hit_i;
    assign above_o = (lvl_o != '0) && (lvl_o > ipl_i);
endmodule

// File: rtl/irq_arm_fsm.sv
module irq_arm_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chk_i,
    input  logic rfe_i,
    input  logic above_i,
    output logic capture_o,
    output logic trap_o
);
    arm_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: begin
                if (chk_i) begin
                    state_d = above_i ? ST_FIRE : ST_DISARMED;
                end
            end
            ST_FIRE: begin
                state_d = rfe_i ? ST_ARMED : ST_DISARMED;
            end
            ST_DISARMED: begin
                if (rfe_i) begin
                    state_d = ST_ARMED;
                end
            end
            default: state_d = ST_DISARMED;
        endcase
    end

    always_comb begin
        capture_o = (state_q == ST_ARMED) && chk_i && above_i;
        trap_o    = (state_q == ST_FIRE);
    end

    // R8: trap lasts a single cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> !trap_o);

    // R9: trap only after an armed check
    a_r9_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> $past(state_q == ST_ARMED && chk_i));

    // R9: an armed check always disarms
    a_r9_check_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && chk_i) |=> (state_q != ST_ARMED));
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
    import irq_pkg::*;
#(
    parameter int P_SUM_W  = SUM_W,
    parameter int P_DATA_W = DATA_W,
    parameter int P_LVL_W  = LVL_W,
    parameter int P_SW_LO  = SW_LO,
    parameter int P_SW_HI  = SW_HI,
    parameter int P_EXT_LO = EXT_LO,
    parameter int P_EXT_HI = EXT_HI
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_wr_i,
    input  logic [P_DATA_W-1:0] sw_wdata_i,
    input  logic                lvl_wr_i,
    input  logic [P_DATA_W-1:0] lvl_wdata_i,
    input  logic [P_SUM_W-1:0]  ext_req_i,
    input  logic                chk_i,
    input  logic                rfe_i,
    output logic                trap_o,
    output logic [P_SUM_W-1:0]  isr_o,
    output logic [P_LVL_W-1:0]  intid_o
);
    localparam int SW_OFS = P_SW_LO - 1;

    function automatic logic [P_SUM_W-1:0] sw_field();
        logic [P_SUM_W-1:0] m;
        for (int i = 0; i < P_SUM_W; i++) begin
            m[i] = (i >= P_SW_LO) && (i < P_SW_HI);
        end
        return m;
    endfunction

    localparam logic [P_SUM_W-1:0] SW_MASK = sw_field();

    logic [P_SUM_W-1:0] sirr_q;
    logic [P_LVL_W-1:0] ipl_q;
    logic [P_SUM_W-1:0] isr_q;
    logic [P_LVL_W-1:0] intid_q;

    logic [P_LVL_W-1:0] sw_lvl, ext_lvl, res_lvl;
    logic [P_SUM_W-1:0] sw_hit, ext_hit, sum;
    logic               above, capture;
    logic               unused_lvl_hi;

    assign unused_lvl_hi = ^lvl_wdata_i[P_DATA_W-1:P_LVL_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sirr_q <= '0;
            ipl_q  <= '0;
        end else begin
            if (sw_wr_i) begin
                sirr_q <= P_SUM_W'(sw_wdata_i) & SW_MASK;
            end
            if (lvl_wr_i) begin
                ipl_q <= lvl_wdata_i[P_LVL_W-1:0];
            end
        end
    end

    irq_prio_scan #(
        .W(P_SUM_W), .LO(P_SW_LO), .HI(P_SW_HI), .OFS(SW_OFS), .LVL_W(P_LVL_W)
    ) u_sw_scan (
        .req_i(sirr_q),
        .lvl_o(sw_lvl),
        .hit_o(sw_hit)
    );

    irq_prio_scan #(
        .W(P_SUM_W), .LO(P_EXT_LO), .HI(P_EXT_HI), .OFS(0), .LVL_W(P_LVL_W)
    ) u_ext_scan (
        .req_i(ext_req_i),
        .lvl_o(ext_lvl),
        .hit_o(ext_hit)
    );

    irq_level_pick #(
        .SUM_W(P_SUM_W), .LVL_W(P_LVL_W), .EXT_WINS(1'b1)
    ) u_pick (
        .sw_lvl_i (sw_lvl),
        .ext_lvl_i(ext_lvl),
        .sw_hit_i (sw_hit),
        .ext_hit_i(ext_hit),
        .ipl_i    (ipl_q),
        .lvl_o    (res_lvl),
        .sum_o    (sum),
        .above_o  (above)
    );

    irq_arm_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .chk_i    (chk_i),
        .rfe_i    (rfe_i),
        .above_i  (above),
        .capture_o(capture),
        .trap_o   (trap_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q   <= '0;
            intid_q <= '0;
        end else if (capture) begin
            isr_q   <= sum;
            intid_q <= res_lvl;
        end
    end

    assign isr_o   = isr_q;
    assign intid_o = intid_q;

    // R5: a taken level lies strictly above the threshold seen at the check
    a_r5_strictly_above: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (intid_o > $past(ipl_q)));

    // R5: a taken level is never zero
    a_r5_nonzero_level: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (intid_o != '0));

    // R7: status holds whenever no trap is issued
    a_r7_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_o |-> ($stable(isr_o) && $stable(intid_o)));

    // R3: an active external level always wins
    a_r3_ext_override: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_lvl != '0) |-> (res_lvl == ext_lvl));
endmodule

// File: tb/irq_level_resolver_bench.sv
module irq_level_resolver_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic        lvl_wr = 1'b0;
    logic [31:0] lvl_wdata = '0;
    logic [31:0] ext_req = '0;
    logic        chk = 1'b0;
    logic        rfe = 1'b0;
    logic        trap;
    logic [31:0] isr;
    logic [4:0]  intid;

    irq_level_resolver u_irq_level_resolver (
        .clk(clk), .rst_n(rst_n),
        .sw_wr_i(sw_wr), .sw_wdata_i(sw_wdata),
        .lvl_wr_i(lvl_wr), .lvl_wdata_i(lvl_wdata),
        .ext_req_i(ext_req), .chk_i(chk), .rfe_i(rfe),
        .trap_o(trap), .isr_o(isr), .intid_o(intid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int          due;
        logic        trap;
        logic [31:0] isr;
        logic [4:0]  id;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 0;

    logic        m_arm;
    logic [31:0] m_sirr;
    logic [4:0]  m_ipl;
    logic [31:0] m_isr;
    logic [4:0]  m_id;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void compare(logic t, logic [31:0] s, logic [4:0] d, string tag);
        n_chk++;
        if (trap !== t || isr !== s || intid !== d) begin
            n_err++;
            $display("FAIL %s: trap=%0b/%0b isr=%h/%h intid=%0d/%0d",
                     tag, trap, t, isr, s, intid, d);
        end
    endfunction

    // monitor: pops expected items when their cycle comes
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                compare(e.trap, e.isr, e.id, e.tag);
            end
        end
    end

    task automatic wr_sw(input logic [31:0] v);
        @(negedge clk); sw_wr = 1'b1; sw_wdata = v;
        @(negedge clk); sw_wr = 1'b0;
        m_sirr = v & 32'h0007_fff0;
    endtask

    task automatic wr_lvl(input logic [31:0] v);
        @(negedge clk); lvl_wr = 1'b1; lvl_wdata = v;
        @(negedge clk); lvl_wr = 1'b0;
        m_ipl = v[4:0];
    endtask

    task automatic pulse_rfe();
        @(negedge clk); rfe = 1'b1;
        @(negedge clk); rfe = 1'b0;
        m_arm = 1'b1;
    endtask

    // driver: applies one check and pushes the expected outcome
    task automatic do_check(input logic [31:0] ext, input logic with_rfe,
                            input logic with_wr, input logic [31:0] wv,
                            input string tag);
        logic [4:0]  sl, el, lv;
        logic [31:0] sum;
        logic        take;
        exp_t        e;
        sl = '0; el = '0;
        for (int i = 4; i <= 18; i++) if (m_sirr[i]) sl = 5'(i - 3);
        for (int i = 20; i <= 29; i++) if (ext[i]) el = 5'(i);
        lv   = (el != 0) ? el : sl;
        sum  = m_sirr | (ext & 32'h3ff0_0000);
        take = m_arm && (lv != 0) && (lv > m_ipl);
        @(negedge clk);
        ext_req = ext; chk = 1'b1; rfe = with_rfe;
        sw_wr = with_wr; sw_wdata = wv;
        if (m_arm) m_arm = 1'b0;
        else if (with_rfe) m_arm = 1'b1;
        if (take) begin m_isr = sum; m_id = lv; end
        if (with_wr) m_sirr = wv & 32'h0007_fff0;
        @(posedge clk);
        #1;
        e.due = cyc; e.trap = take; e.isr = m_isr; e.id = m_id; e.tag = tag;
        q.push_back(e);
        e.due = cyc + 1; e.trap = 1'b0; e.tag = {tag, " / R8 pulse ends"};
        q.push_back(e);
        @(negedge clk);
        chk = 1'b0; rfe = 1'b0; sw_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        m_arm = 1'b1; m_sirr = '0; m_ipl = '0; m_isr = '0; m_id = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare(1'b0, 32'h0, 5'd0, "R10 reset state");

        wr_sw(32'h0000_0010);
        do_check(32'h0, 0, 0, 0, "R1 sw bit4 -> level 1");
        do_check(32'h0040_0000, 0, 0, 0, "R9 disarmed check ignored");
        pulse_rfe();
        wr_sw(32'hffff_ffff);
        do_check(32'h0, 0, 0, 0, "R1 mask and top sw level 15");
        pulse_rfe();
        wr_sw(32'h0);
        do_check(32'h8210_0008, 0, 0, 0, "R2 ext window, R3 highest");
        pulse_rfe();
        wr_sw(32'h0000_0100);
        do_check(32'h0020_0000, 0, 0, 0, "R3 ext overrides sw, R4 summary");
        pulse_rfe();
        wr_lvl(32'h0000_0035);
        do_check(32'h0020_0000, 0, 0, 0, "R5 equal level no trap, R6");
        pulse_rfe();
        do_check(32'h0040_0000, 0, 0, 0, "R5 one above threshold");
        pulse_rfe();
        wr_lvl(32'h0000_002e);
        wr_sw(32'h0007_fff0);
        do_check(32'h0, 0, 0, 0, "R5 sw 15 over 14, R6");
        pulse_rfe();
        wr_lvl(32'h0000_00ef);
        do_check(32'h0, 0, 0, 0, "R5 sw 15 equal 15, R6");
        pulse_rfe();
        wr_lvl(32'hffff_ffff);
        do_check(32'h2000_0000, 0, 0, 0, "R5 ext 29 under 31, R6");
        pulse_rfe();
        wr_lvl(32'h0);
        wr_sw(32'h0);
        do_check(32'h0, 0, 0, 0, "R5 zero level never traps");
        do_check(32'h0080_0000, 1, 0, 0, "R9 rearm with check does not evaluate");
        do_check(32'h0080_0000, 0, 0, 0, "R9 after rearm ext 23 traps");
        pulse_rfe();
        do_check(32'h0, 0, 1, 32'h0004_0000, "R11 same-cycle write not seen");
        pulse_rfe();
        do_check(32'h0, 0, 0, 0, "R11 written bit18 -> level 15, R7");

        repeat (4) @(negedge clk);
        n_chk++;
        if (q.size() != 0) begin
            n_err++;
            $display("FAIL scoreboard: %0d items left, expected 0", q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule